// File: doc/BRIEF.md
# Timer Input Glitch Filter with Edge Detection

This block conditions five asynchronous timer inputs before they reach a timer's capture or trigger logic. Four are capture/compare channels and one is an external trigger. Each input passes through a two-flop synchroniser. It then goes through a majority-free "three in a row" filter. The filter commits a new level only when the incoming sample and the two previously taken samples all agree. A short disturbance therefore never reaches the timer.

Samples are taken on a strobe, which is a single-cycle enable in the system clock domain. The strobe can be one of four choices:
- every clock;
- every 8th clock;
- every 32nd clock;
- the timer's own count source. That source is itself picked from the clock divided by 1, 2, 4, 8 or 32, or from rising edges of an external clock pin.

Per channel, an enable chooses between the filtered level and the synchronised raw level. A polarity-selectable edge detector turns the chosen level into one-cycle event pulses. All pins are plain control or level signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `capture_input_filter`

## Requirements
- R1: While reset is asserted, every level output and every edge output is 0, regardless of the raw inputs.
- R2: With the filter enabled and a strobe on every clock, a raw change applied between clock edges appears on the level output after exactly the fifth rising clock edge: two synchroniser stages, then three agreeing samples.
- R3: With the filter enabled, a new level that holds for fewer than three consecutive strobes is discarded. The level output keeps its previously confirmed value and produces no edge pulse.
- R4: With the filter enable at 0, the level output follows the raw input after the second rising clock edge, and glitches are not removed.
- R5: `smp_sel` encodes the strobe: 00 = clock/32, 01 = clock/8, 10 = every clock, 11 = count source. A held change is confirmed within five strobe periods plus two synchroniser cycles.
- R6: `cnt_sel` encodes the count source: 000 = /1, 001 = /2, 010 = /4, 011 = /8, 100 = /32, 101 = each rising edge of the synchronised external clock pin, 110 and 111 = no strobe. When no strobe occurs, the filtered level is frozen.
- R7: The edge mode encodes 00 = rising, 01 = falling, 10 = both, 11 = none. Each qualifying change of the chosen level gives exactly one single-cycle pulse, in the same cycle the level changes.
- R8: Channels are independent. IO channel j uses `flt_en_io[j]` and `io_edge_mode[2j+1:2j]`. The trigger uses `flt_en_trig` and `trig_edge_mode`. Only the strobe is shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_io | input | 4 | Asynchronous capture/compare inputs, channels 0..3 |
| raw_trig | input | 1 | Asynchronous external trigger input |
| ext_clk_pin | input | 1 | External count-source pin (asynchronous) |
| cnt_sel | input | 3 | Count-source select (R6) |
| smp_sel | input | 2 | Sampling-strobe select (R5) |
| flt_en_io | input | 4 | Per IO channel: 1 = filtered, 0 = bypass |
| flt_en_trig | input | 1 | Trigger: 1 = filtered, 0 = bypass |
| io_edge_mode | input | 8 | Two-bit edge mode per IO channel (R7) |
| trig_edge_mode | input | 2 | Edge mode for the trigger (R7) |
| lvl_io | output | 4 | Conditioned levels of the IO channels |
| lvl_trig | output | 1 | Conditioned level of the trigger |
| edge_io | output | 4 | One-cycle edge pulses of the IO channels |
| edge_trig | output | 1 | One-cycle edge pulse of the trigger |

## Verification
The bench pins down the exact five-edge latency at full rate. A filter with one sample too few or too many, or with a missing synchroniser stage, shifts the level by a cycle and is caught. Pulses lasting exactly two strobes are applied at full rate, at /8, at /32 and at the /2 count source. A filter that commits on two agreeing samples, or that samples on the wrong divider, lets these through. The external-pin source is held still and then toggled, which exposes a strobe that ignores the pin or runs free. Each edge mode is counted over a rise and a fall, and a mixed filtered/bypass setup shows whether enables or modes leak between channels.

// File: rtl/cif_pkg.sv
package cif_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  localparam logic [1:0] SMP_SLOW = 2'b00;
  localparam logic [1:0] SMP_MID  = 2'b01;
  localparam logic [1:0] SMP_FULL = 2'b10;
  localparam logic [1:0] SMP_CNT  = 2'b11;

  localparam logic [2:0] CNT_D1   = 3'b000;
  localparam logic [2:0] CNT_D2   = 3'b001;
  localparam logic [2:0] CNT_D4   = 3'b010;
  localparam logic [2:0] CNT_MID  = 3'b011;
  localparam logic [2:0] CNT_SLOW = 3'b100;
  localparam logic [2:0] CNT_EXT  = 3'b101;

endpackage

// File: rtl/cif_strobe_gen.sv
module cif_strobe_gen
  import cif_pkg::*;
#(
  parameter int SLOW_LG = 5,
  parameter int MID_LG  = 3,
  parameter int SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_pin,
  input  logic [2:0] cnt_sel,
  input  logic [1:0] smp_sel,
  output logic       smp_stb
);

  localparam int PRE_W = SLOW_LG;
  localparam int EXT_W = SYNC + 1;

  logic [PRE_W-1:0] pre;
  logic [EXT_W-1:0] ext_q;
  logic             ext_rise;
  logic             cnt_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ext_q <= '0;
    end else begin
      pre   <= pre + 1'b1;
      ext_q <= {ext_q[EXT_W-2:0], ext_pin};
    end
  end

  assign ext_rise = ext_q[EXT_W-2] & ~ext_q[EXT_W-1];

  function automatic logic tick_at(input logic [PRE_W-1:0] cnt, input int lg);
    logic [PRE_W-1:0] msk;
    msk = PRE_W'((1 << lg) - 1);
    return (cnt & msk) == msk;
  endfunction

  always_comb begin
    unique case (cnt_sel)
      CNT_D1:   cnt_tick = 1'b1;
      CNT_D2:   cnt_tick = tick_at(pre, 1);
      CNT_D4:   cnt_tick = tick_at(pre, 2);
      CNT_MID:  cnt_tick = tick_at(pre, MID_LG);
      CNT_SLOW: cnt_tick = tick_at(pre, SLOW_LG);
      CNT_EXT:  cnt_tick = ext_rise;
      default:  cnt_tick = 1'b0;
    endcase
  end

  always_comb begin
    unique case (smp_sel)
      SMP_SLOW: smp_stb = tick_at(pre, SLOW_LG);
      SMP_MID:  smp_stb = tick_at(pre, MID_LG);
      SMP_FULL: smp_stb = 1'b1;
      default:  smp_stb = cnt_tick;
    endcase
  end

  // R5
  mid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_sel == SMP_MID && smp_stb) ##1 (smp_sel == SMP_MID) |-> !smp_stb);

  // R6
  ext_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_sel == SMP_CNT && cnt_sel == CNT_EXT && smp_stb)
      ##1 (smp_sel == SMP_CNT && cnt_sel == CNT_EXT) |-> !smp_stb);

endmodule

// File: rtl/cif_chan.sv
module cif_chan
  import cif_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic       stb,
  input  logic       flt_en,
  input  edge_mode_e mode,
  output logic       lvl,
  output logic       edg
);

  logic [SYNC-1:0] sy;
  logic            s_in;
  logic            t0, t1;
  logic            conf;
  logic            prev;

  assign s_in = sy[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      t0   <= 1'b0;
      t1   <= 1'b0;
      conf <= 1'b0;
      prev <= 1'b0;
    end else begin
      sy   <= {sy[SYNC-2:0], raw};
      prev <= lvl;
      if (stb) begin
        t0 <= s_in;
        t1 <= t0;
        if (s_in == t0 && t0 == t1) conf <= s_in;
      end
    end
  end

  assign lvl = flt_en ? conf : s_in;

  always_comb begin
    unique case (mode)
      EDGE_RISE: edg = lvl & ~prev;
      EDGE_FALL: edg = ~lvl & prev;
      EDGE_BOTH: edg = lvl ^ prev;
      default:   edg = 1'b0;
    endcase
  end

  // R2
  conf_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf != $past(conf)) |-> ($past(s_in) == conf && $past(t0) == conf && $past(t1) == conf));

  // R3
  conf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb) |-> $stable(conf));

  // R7
  edge_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edg |-> (lvl != prev));

endmodule

// File: rtl/capture_input_filter.sv
module capture_input_filter
  import cif_pkg::*;
#(
  parameter int NIO     = 4,
  parameter int SYNC    = 2,
  parameter int SLOW_LG = 5,
  parameter int MID_LG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIO-1:0]   raw_io,
  input  logic             raw_trig,
  input  logic             ext_clk_pin,
  input  logic [2:0]       cnt_sel,
  input  logic [1:0]       smp_sel,
  input  logic [NIO-1:0]   flt_en_io,
  input  logic             flt_en_trig,
  input  logic [2*NIO-1:0] io_edge_mode,
  input  logic [1:0]       trig_edge_mode,
  output logic [NIO-1:0]   lvl_io,
  output logic             lvl_trig,
  output logic [NIO-1:0]   edge_io,
  output logic             edge_trig
);

  localparam int NCH = NIO + 1;

  logic             stb;
  logic [NCH-1:0]   raw_all, en_all, lvl_all, edg_all;
  logic [2*NCH-1:0] mode_all;

  assign raw_all  = {raw_trig, raw_io};
  assign en_all   = {flt_en_trig, flt_en_io};
  assign mode_all = {trig_edge_mode, io_edge_mode};

  cif_strobe_gen #(.SLOW_LG(SLOW_LG), .MID_LG(MID_LG), .SYNC(SYNC)) u_stb (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_pin (ext_clk_pin),
    .cnt_sel (cnt_sel),
    .smp_sel (smp_sel),
    .smp_stb (stb)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cif_chan #(.SYNC(SYNC)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_all[i]),
      .stb    (stb),
      .flt_en (en_all[i]),
      .mode   (edge_mode_e'(mode_all[2*i +: 2])),
      .lvl    (lvl_all[i]),
      .edg    (edg_all[i])
    );
  end

  assign lvl_io    = lvl_all[NIO-1:0];
  assign lvl_trig  = lvl_all[NIO];
  assign edge_io   = edg_all[NIO-1:0];
  assign edge_trig = edg_all[NIO];

endmodule

// File: tb/sim_capture_input_filter.sv
`timescale 1ns/1ps
module sim_capture_input_filter;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] raw_io = 0;
  logic       raw_trig = 0;
  logic       ext_clk_pin = 0;
  logic [2:0] cnt_sel = 0;
  logic [1:0] smp_sel = 2'b10;
  logic [3:0] flt_en_io = 0;
  logic       flt_en_trig = 0;
  logic [7:0] io_edge_mode = 0;
  logic [1:0] trig_edge_mode = 0;
  logic [3:0] lvl_io, edge_io;
  logic       lvl_trig, edge_trig;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_io [4];
  int cnt_trig;
  bit done = 0;

  always #5 clk = ~clk;

  capture_input_filter u0 (
    .clk(clk), .rst_n(rst_n), .raw_io(raw_io), .raw_trig(raw_trig),
    .ext_clk_pin(ext_clk_pin), .cnt_sel(cnt_sel), .smp_sel(smp_sel),
    .flt_en_io(flt_en_io), .flt_en_trig(flt_en_trig),
    .io_edge_mode(io_edge_mode), .trig_edge_mode(trig_edge_mode),
    .lvl_io(lvl_io), .lvl_trig(lvl_trig), .edge_io(edge_io), .edge_trig(edge_trig)
  );

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) cnt_io[k] += int'(edge_io[k]);
    cnt_trig += int'(edge_trig);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    @(posedge clk);
    for (int k = 0; k < 4; k++) cnt_io[k] = 0;
    cnt_trig = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    smp_sel = 2'b10;
    wait_n(10);
  endtask

  task automatic t_reset();
    raw_io = 4'hF; raw_trig = 1;
    wait_n(4);
    chk("R1 lvl_io", lvl_io, 0);
    chk("R1 lvl_trig", lvl_trig, 0);
    chk("R1 edges", {edge_trig, edge_io}, 0);
    raw_io = 0; raw_trig = 0;
    wait_n(2);
    rst_n = 1;
  endtask

  task automatic t_latency();
    flt_en_io[0] = 1; io_edge_mode[1:0] = 2'b00;
    settle();
    clr_cnt();
    @(negedge clk) raw_io[0] = 1;
    wait_n(4);
    chk("R2 not yet at edge 4", lvl_io[0], 0);
    wait_n(1);
    chk("R2 level at edge 5", lvl_io[0], 1);
    chk("R7 rising pulse", edge_io[0], 1);
    wait_n(1);
    chk("R7 pulse one cycle", edge_io[0], 0);
  endtask

  task automatic t_glitch();
    io_edge_mode[1:0] = 2'b10;
    settle();
    clr_cnt();
    @(negedge clk) raw_io[0] = 0;
    @(negedge clk);
    @(negedge clk) raw_io[0] = 1;
    wait_n(10);
    chk("R3 two-sample glitch held", lvl_io[0], 1);
    chk("R3 no pulse on glitch", cnt_io[0], 0);
    @(negedge clk) raw_io[0] = 0;
    wait_n(3);
    raw_io[0] = 1;
    wait_n(2);
    chk("R2 three-sample low accepted", lvl_io[0], 0);
    wait_n(10);
    chk("R2 back high", lvl_io[0], 1);
    chk("R7 both edges counted", cnt_io[0], 2);
  endtask

  task automatic t_bypass();
    flt_en_io[1] = 0; io_edge_mode[3:2] = 2'b10;
    settle();
    clr_cnt();
    @(negedge clk) raw_io[1] = 1;
    @(negedge clk) raw_io[1] = 0;
    @(negedge clk);
    chk("R4 bypass passes glitch", lvl_io[1], 1);
    @(negedge clk);
    chk("R4 bypass follows fall", lvl_io[1], 0);
    wait_n(5);
    chk("R7 both mode bypass pulses", cnt_io[1], 2);
  endtask

  task automatic t_edge_modes();
    int exp_cnt [4] = '{1, 1, 2, 0};
    flt_en_io[2] = 0;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk) io_edge_mode[5:4] = 2'(m);
      wait_n(4);
      clr_cnt();
      @(negedge clk) raw_io[2] = 1;
      wait_n(5);
      raw_io[2] = 0;
      wait_n(5);
      chk($sformatf("R7 mode %0d pulse count", m), cnt_io[2], exp_cnt[m]);
    end
  endtask

  task automatic t_div8();
    flt_en_io[3] = 1; io_edge_mode[7:6] = 2'b00;
    settle();
    @(negedge clk) smp_sel = 2'b01;
    clr_cnt();
    @(negedge clk) raw_io[3] = 1;
    wait_n(16);
    raw_io[3] = 0;
    wait_n(60);
    chk("R5 div8 two-strobe pulse rejected", cnt_io[3], 0);
    raw_io[3] = 1;
    wait_n(5);
    chk("R5 div8 not at full rate", lvl_io[3], 0);
    wait_n(37);
    chk("R5 div8 within five periods", lvl_io[3], 1);
  endtask

  task automatic t_div32();
    flt_en_trig = 1; trig_edge_mode = 2'b00;
    settle();
    @(negedge clk) smp_sel = 2'b00;
    clr_cnt();
    @(negedge clk) raw_trig = 1;
    wait_n(64);
    raw_trig = 0;
    wait_n(200);
    chk("R5 div32 pulse rejected", cnt_trig, 0);
    raw_trig = 1;
    wait_n(40);
    chk("R5 div32 not at div8 rate", lvl_trig, 0);
    wait_n(122);
    chk("R5 div32 within five periods", lvl_trig, 1);
  endtask

  task automatic t_cnt_src();
    raw_io[0] = 0;
    settle();
    @(negedge clk) begin smp_sel = 2'b11; cnt_sel = 3'b001; end
    clr_cnt();
    @(negedge clk) raw_io[0] = 1;
    wait_n(4);
    raw_io[0] = 0;
    wait_n(20);
    chk("R6 div2 two-strobe pulse rejected", cnt_io[0], 0);
    raw_io[0] = 1;
    wait_n(14);
    chk("R6 div2 source confirms", lvl_io[0], 1);
  endtask

  task automatic t_ext();
    @(negedge clk) begin cnt_sel = 3'b101; ext_clk_pin = 0; end
    raw_io[0] = 0;
    wait_n(50);
    chk("R6 idle ext pin freezes level", lvl_io[0], 1);
    for (int k = 0; k < 4; k++) begin
      ext_clk_pin = 1; wait_n(3);
      ext_clk_pin = 0; wait_n(3);
    end
    wait_n(8);
    chk("R6 ext pin edges confirm", lvl_io[0], 0);
    cnt_sel = 3'b110;
    raw_io[0] = 1;
    wait_n(50);
    chk("R6 reserved source gives no strobe", lvl_io[0], 0);
  endtask

  task automatic t_indep();
    flt_en_io[0] = 1; io_edge_mode[1:0] = 2'b10;
    flt_en_io[1] = 0; io_edge_mode[3:2] = 2'b10;
    flt_en_trig = 0; trig_edge_mode = 2'b01;
    raw_io[0] = 0; raw_io[1] = 0; raw_trig = 0;
    settle();
    clr_cnt();
    @(negedge clk) begin raw_io[0] = 1; raw_io[1] = 1; raw_trig = 1; end
    @(negedge clk);
    @(negedge clk) begin raw_io[0] = 0; raw_io[1] = 0; raw_trig = 0; end
    wait_n(10);
    chk("R8 filtered channel ignores glitch", cnt_io[0], 0);
    chk("R8 bypass channel sees both edges", cnt_io[1], 2);
    chk("R8 trigger falling only", cnt_trig, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) cnt_io[k] = 0;
    cnt_trig = 0;
    t_reset();
    t_latency();
    t_glitch();
    t_bypass();
    t_edge_modes();
    t_div8();
    t_div32();
    t_cnt_src();
    t_ext();
    t_indep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule